// File: doc/BRIEF.md
# Cascaded FIFO Depth-Expansion Ring

This block builds one deep FIFO out of several identical storage devices chained in a ring. Every device has its own small memory and its own read and write location counters. Two tokens circulate around the ring. The write token marks the single device that accepts incoming words, and the read token marks the single device that supplies outgoing words. The device that was named as the first loader during reset starts with both tokens.

When the token holder writes its highest physical location, it drives a one-cycle active-low handoff pulse to the next device in the ring, and the write token moves there. Reading the highest location sends the read token onward in the same way. Both kinds of handoff share one line between neighbours. A receiving device tells them apart by remembering which token it expects next, because write and read arrivals always alternate at any one device. Each device has active-low full and empty flags, and the composite flags are the OR of these. The result behaves as one FIFO of NDEV*DEPTH words. The two tokens move independently of each other.

Top module: `dx_fifo_ring`

## Requirements
- R1: While rst is high and on its release, the device k whose first_load_n bit is 0 holds both tokens: wr_sel and rd_sel both equal the one-hot value with only bit k set. empty_n is 0, full_n is 1 and rd_valid is 0.
- R2: An accepted write that lands on the holder's last physical location (the DEPTH-th accepted write since the holder received the token) moves wr_sel from bit k to bit (k+1) mod NDEV after the same clock edge.
- R3: An accepted read from the holder's last physical location (the DEPTH-th accepted read since the holder received the token) moves rd_sel from bit k to bit (k+1) mod NDEV after the same clock edge.
- R4: After reset, wr_sel and rd_sel each have exactly one bit set on every cycle.
- R5: Words come out in the order they were written, across device boundaries and across the wrap from the last device back to the first. A read accepted at clock edge t shows rd_valid=1 with its word on rd_data after edge t+1, for one cycle.
- R6: full_n (active low) is 0 exactly when NDEV*DEPTH words are stored. A write offered while full_n is 0 is dropped and never appears at the output.
- R7: empty_n (active low) is 0 exactly when no word is stored. A read offered while empty_n is 0 is dropped: no rd_valid pulse follows and rd_sel does not move.
- R8: A write offered while full_n is 0 is dropped even when a read is accepted at the same edge. After that edge full_n is 1.
- R9: The write token advances without the read token: writes alone move wr_sel while rd_sel stays at its device.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| first_load_n | input | NDEV | Active-low first-loader select, sampled during reset; exactly one bit low |
| wr_en | input | 1 | Write request |
| wr_data | input | WIDTH | Write word |
| rd_en | input | 1 | Read request |
| rd_data | output | WIDTH | Read word, meaningful while rd_valid is 1 |
| rd_valid | output | 1 | Read word present |
| full_n | output | 1 | Composite full flag, low when full |
| empty_n | output | 1 | Composite empty flag, low when empty |
| wr_sel | output | NDEV | One-hot write token position |
| rd_sel | output | NDEV | One-hot read token position |

## Verification
The assertions watch four things on every cycle: each token is held by exactly one device, a device gives up a token after emitting the matching handoff pulse, a device takes the token it expects after a pulse arrives, and no device ever holds more than DEPTH words or fires both handoffs at once. Only the bench's scenarios can show end-to-end behaviour. These are ordered data across device boundaries and the ring wrap, dropped writes at full and dropped reads at empty, the write that is refused at full even when a read happens in the same cycle, and a start from a first loader other than device 0.

// File: rtl/dx_pkg.sv
package dx_pkg;
  // Which token a device expects to receive with its next incoming pulse
  typedef enum logic {
    DUE_WR = 1'b0,
    DUE_RD = 1'b1
  } due_e;
endpackage

// File: rtl/dx_store.sv
module dx_store #(
  parameter int WIDTH = 9,
  parameter int DEPTH = 4,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] q,
  output logic             q_vld
);
  logic [WIDTH-1:0] mem [DEPTH];

  // Plain write port and registered read port, so block RAM can be inferred
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) q <= mem[raddr];
  end

  always_ff @(posedge clk) begin
    if (rst) q_vld <= 1'b0;
    else     q_vld <= re;
  end
endmodule

// File: rtl/dx_loc_ctr.sv
module dx_loc_ctr #(
  parameter int DEPTH = 4,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_fire,
  input  logic          rd_fire,
  output logic [AW-1:0] wptr,
  output logic [AW-1:0] rptr,
  output logic          full_n,
  output logic          empty_n,
  output logic          wr_last,
  output logic          rd_last
);
  localparam logic [AW:0]   CAP     = (AW+1)'(DEPTH);
  localparam logic [AW-1:0] LASTLOC = {AW{1'b1}};

  logic [AW:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (wr_fire) wptr <= wptr + 1'b1;
      if (rd_fire) rptr <= rptr + 1'b1;
      case ({wr_fire, rd_fire})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign full_n  = (cnt != CAP);
  assign empty_n = (cnt != '0);
  assign wr_last = wr_fire && (wptr == LASTLOC);
  assign rd_last = rd_fire && (rptr == LASTLOC);

  // R6
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= CAP);

  // R6
  full_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!full_n && !rd_fire) |=> (!full_n && $stable(wptr)));

  // R7
  empty_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!empty_n && !wr_fire) |=> (!empty_n && $stable(rptr)));
endmodule

// File: rtl/dx_token_ctrl.sv
module dx_token_ctrl
  import dx_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic fl_n,
  input  logic wr_last,
  input  logic rd_last,
  input  logic xi_n,
  output logic xo_n,
  output logic wr_tok,
  output logic rd_tok
);
  due_e due;

  // Handoff pulse, low for the cycle in which the last location is used
  assign xo_n = !(wr_last || rd_last);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_tok <= !fl_n;
      rd_tok <= !fl_n;
      due    <= DUE_WR;
    end else begin
      if (wr_last) wr_tok <= 1'b0;
      if (rd_last) rd_tok <= 1'b0;
      if (!xi_n) begin
        if (due == DUE_WR) begin
          wr_tok <= 1'b1;
          due    <= DUE_RD;
        end else begin
          rd_tok <= 1'b1;
          due    <= DUE_WR;
        end
      end
    end
  end

  // R2
  wr_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_last && xi_n) |=> !wr_tok);

  // R3
  rd_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_last && xi_n) |=> !rd_tok);

  // R2
  wr_take_chk: assert property (@(posedge clk) disable iff (rst)
    (!xi_n && due == DUE_WR) |=> wr_tok);

  // R3
  rd_take_chk: assert property (@(posedge clk) disable iff (rst)
    (!xi_n && due == DUE_RD) |=> rd_tok);

  // R4
  wr_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_tok && !wr_last) |=> wr_tok);
endmodule

// File: rtl/dx_node.sv
module dx_node #(
  parameter int WIDTH = 9,
  parameter int DEPTH = 4,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fl_n,
  input  logic             wr_req,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_req,
  input  logic             xi_n,
  output logic             xo_n,
  output logic             wr_tok,
  output logic             rd_tok,
  output logic             full_n,
  output logic             empty_n,
  output logic [WIDTH-1:0] q,
  output logic             q_vld
);
  logic [AW-1:0] wptr, rptr;
  logic          wr_fire, rd_fire, wr_last, rd_last;

  assign wr_fire = wr_req && wr_tok && full_n;
  assign rd_fire = rd_req && rd_tok && empty_n;

  dx_loc_ctr #(.DEPTH(DEPTH)) u_ctr (
    .clk     (clk),
    .rst     (rst),
    .wr_fire (wr_fire),
    .rd_fire (rd_fire),
    .wptr    (wptr),
    .rptr    (rptr),
    .full_n  (full_n),
    .empty_n (empty_n),
    .wr_last (wr_last),
    .rd_last (rd_last)
  );

  dx_token_ctrl u_tok (
    .clk     (clk),
    .rst     (rst),
    .fl_n    (fl_n),
    .wr_last (wr_last),
    .rd_last (rd_last),
    .xi_n    (xi_n),
    .xo_n    (xo_n),
    .wr_tok  (wr_tok),
    .rd_tok  (rd_tok)
  );

  dx_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_mem (
    .clk   (clk),
    .rst   (rst),
    .we    (wr_fire),
    .waddr (wptr),
    .wdata (wr_data),
    .re    (rd_fire),
    .raddr (rptr),
    .q     (q),
    .q_vld (q_vld)
  );

  // R5: one handoff line, so both last locations never coincide
  dual_last_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_last && rd_last));
endmodule

// File: rtl/dx_fifo_ring.sv
module dx_fifo_ring #(
  parameter int NDEV  = 4,
  parameter int DEPTH = 4,
  parameter int WIDTH = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NDEV-1:0]  first_load_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_valid,
  output logic             full_n,
  output logic             empty_n,
  output logic [NDEV-1:0]  wr_sel,
  output logic [NDEV-1:0]  rd_sel
);
  logic [NDEV-1:0]  xo_n, xi_n, dev_full_n, dev_empty_n, dev_vld;
  logic [WIDTH-1:0] dev_q [NDEV];
  logic [WIDTH-1:0] mux_q;
  logic             any_vld;

  for (genvar g = 0; g < NDEV; g++) begin : g_dev
    localparam int PREV = (g + NDEV - 1) % NDEV;
    assign xi_n[g] = xo_n[PREV];

    dx_node #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_node (
      .clk     (clk),
      .rst     (rst),
      .fl_n    (first_load_n[g]),
      .wr_req  (wr_en),
      .wr_data (wr_data),
      .rd_req  (rd_en),
      .xi_n    (xi_n[g]),
      .xo_n    (xo_n[g]),
      .wr_tok  (wr_sel[g]),
      .rd_tok  (rd_sel[g]),
      .full_n  (dev_full_n[g]),
      .empty_n (dev_empty_n[g]),
      .q       (dev_q[g]),
      .q_vld   (dev_vld[g])
    );
  end

  // Composite active-low flags
  assign full_n  = |dev_full_n;
  assign empty_n = |dev_empty_n;

  always_comb begin
    mux_q   = '0;
    any_vld = 1'b0;
    for (int i = 0; i < NDEV; i++) begin
      any_vld = any_vld | dev_vld[i];
      if (dev_vld[i]) mux_q = mux_q | dev_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= any_vld;
      rd_data  <= mux_q;
    end
  end

  // R4
  wr_one_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(wr_sel) == 1);

  // R4
  rd_one_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(rd_sel) == 1);

  // R5
  vld_one_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(dev_vld));
endmodule

// File: tb/dx_fifo_ring_test.sv
`timescale 1ns/100ps
module dx_fifo_ring_test;
  localparam int NDEV  = 4;
  localparam int DEPTH = 4;
  localparam int WIDTH = 9;
  localparam int CAP   = NDEV * DEPTH;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [NDEV-1:0]  first_load_n = '1;
  logic             wr_en = 1'b0;
  logic [WIDTH-1:0] wr_data = '0;
  logic             rd_en = 1'b0;
  logic [WIDTH-1:0] rd_data;
  logic             rd_valid, full_n, empty_n;
  logic [NDEV-1:0]  wr_sel, rd_sel;

  dx_fifo_ring #(.NDEV(NDEV), .DEPTH(DEPTH), .WIDTH(WIDTH)) uut (
    .clk(clk), .rst(rst), .first_load_n(first_load_n),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .rd_valid(rd_valid),
    .full_n(full_n), .empty_n(empty_n),
    .wr_sel(wr_sel), .rd_sel(rd_sel)
  );

  always #2.5 clk = ~clk;

  int nchk = 0, nerr = 0;
  logic [WIDTH-1:0] mq [$];
  int seq = 1;
  int wp, wc, rp, rc;
  bit pv;
  logic [WIDTH-1:0] pd;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int oh(input int k);
    return 1 << k;
  endfunction

  task automatic do_reset(input int k);
    @(negedge clk);
    rst = 1'b1;
    wr_en = 1'b0;
    rd_en = 1'b0;
    first_load_n = ~NDEV'(oh(k));
    repeat (2) @(negedge clk);
    rst = 1'b0;
    mq.delete();
    wp = k; rp = k; wc = 0; rc = 0; pv = 0;
  endtask

  // One clock cycle with optional write and read; checks the outputs afterwards
  task automatic step(input bit we, input bit re);
    bit wok, rok;
    logic [WIDTH-1:0] d, rexp;
    d = seq[WIDTH-1:0];
    seq++;
    wr_en = we; wr_data = d; rd_en = re;
    wok = we && (mq.size() < CAP);
    rok = re && (mq.size() > 0);
    rexp = '0;
    if (rok) rexp = mq.pop_front();
    if (wok) mq.push_back(d);
    if (wok) begin
      wc++;
      if (wc == DEPTH) begin wc = 0; wp = (wp + 1) % NDEV; end
    end
    if (rok) begin
      rc++;
      if (rc == DEPTH) begin rc = 0; rp = (rp + 1) % NDEV; end
    end
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    chk(rd_valid == pv, "R5/R7 rd_valid", int'(rd_valid), int'(pv));
    if (pv) chk(rd_data == pd, "R5 rd_data order", int'(rd_data), int'(pd));
    chk(wr_sel == NDEV'(oh(wp)), "R2/R4 wr_sel", int'(wr_sel), oh(wp));
    chk(rd_sel == NDEV'(oh(rp)), "R3/R4 rd_sel", int'(rd_sel), oh(rp));
    chk(full_n == (mq.size() != CAP), "R6 full_n", int'(full_n), int'(mq.size() != CAP));
    chk(empty_n == (mq.size() != 0), "R7 empty_n", int'(empty_n), int'(mq.size() != 0));
    pv = rok; pd = rexp;
  endtask

  task automatic flush();
    while (mq.size() > 0) step(1'b0, 1'b1);
    repeat (2) step(1'b0, 1'b0);
  endtask

  task automatic t_reset(input int k);
    do_reset(k);
    chk(wr_sel == NDEV'(oh(k)), "R1 wr_sel", int'(wr_sel), oh(k));
    chk(rd_sel == NDEV'(oh(k)), "R1 rd_sel", int'(rd_sel), oh(k));
    chk(empty_n == 1'b0, "R1 empty_n", int'(empty_n), 0);
    chk(full_n == 1'b1, "R1 full_n", int'(full_n), 1);
    chk(rd_valid == 1'b0, "R1 rd_valid", int'(rd_valid), 0);
  endtask

  task automatic t_independent();
    t_reset(0);
    repeat (10) step(1'b1, 1'b0);
    chk(wr_sel == NDEV'(oh(2)), "R9 wr_sel advanced", int'(wr_sel), oh(2));
    chk(rd_sel == NDEV'(oh(0)), "R9 rd_sel held", int'(rd_sel), oh(0));
    flush();
  endtask

  task automatic t_fill_drain();
    t_reset(0);
    repeat (CAP) step(1'b1, 1'b0);
    chk(full_n == 1'b0, "R6 full after fill", int'(full_n), 0);
    repeat (3) step(1'b1, 1'b0);
    repeat (CAP) step(1'b0, 1'b1);
    repeat (3) step(1'b0, 1'b1);
    chk(rd_sel == NDEV'(oh(0)), "R7 rd_sel still after empty reads", int'(rd_sel), 1);
    repeat (2) step(1'b0, 1'b0);
  endtask

  task automatic t_full_same_cycle();
    t_reset(1);
    repeat (CAP) step(1'b1, 1'b0);
    step(1'b1, 1'b1);
    chk(full_n == 1'b1, "R8 write dropped beside read", int'(full_n), 1);
    flush();
  endtask

  task automatic t_stream(input int k, input int n);
    logic [15:0] lfsr;
    bit phase;
    t_reset(k);
    lfsr = 16'hACE1;
    phase = 1'b0;
    for (int i = 0; i < n; i++) begin
      bit we, re;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (i % 50 == 0) phase = ~phase;
      we = phase ? (lfsr[1:0] != 2'b00) : (lfsr[1:0] == 2'b00);
      re = phase ? (lfsr[3:2] == 2'b00) : (lfsr[3:2] != 2'b00);
      step(we, re);
    end
    flush();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    t_reset(0);
    t_reset(3);
    t_independent();
    t_fill_drain();
    t_full_same_cycle();
    t_stream(0, 600);
    t_stream(2, 600);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule